// File: doc/BRIEF.md
# Sequential restoring integer divider

This block divides one 32-bit integer by another over several clock cycles and returns a quotient and a remainder. A single wide shift register does double duty: its upper part carries the running partial remainder, while its lower part starts out holding the dividend and fills up with quotient bits as the dividend bits move upward. One trial subtractor, one bit wider than the operands, serves every step. When a trial difference is negative, the register keeps its old upper part, which gives the same result as adding the divisor back. The whole register is shifted once before the loop starts. That puts one shift too many into the remainder, so a last step moves only the upper part back right by one.

For signed division, the operands are first turned into their magnitudes and divided as unsigned numbers. The quotient is then negated when the two operand signs differ, and the remainder takes the sign of the dividend. The caller raises `start` for one cycle while `busy` is low. It then waits for the single-cycle `done` pulse and reads `quotient` and `remainder`, which stay at their values until the next division finishes.

The controller has five states. **IDLE** accepts a request, loads the operand magnitudes and sign flags, and moves to **PRE**. **PRE** performs the initial left shift and moves to **ITER**. **ITER** runs one trial subtraction and one shift per cycle, and moves to **FIX** after the last of W steps. **FIX** shifts the remainder part right, fixes the signs, registers both results and moves to **DONE**. **DONE** pulses `done` and returns to **IDLE**.

Top module: `restoring_divider`

## Requirements
- R1: While reset is applied and right after it, busy, done, quotient and remainder are all 0.
- R2: A start that is sampled while busy is low makes busy go high on the next cycle. Busy stays high up to and including the cycle in which done is high, and is low in the cycle after that.
- R3: done is high for exactly one cycle. It rises after the (W+2)-th rising clock edge that follows the edge on which start was accepted, which is 34 edges for W = 32.
- R4: With is_signed = 0, quotient equals floor(dividend / divisor) and remainder equals dividend mod divisor. This holds for full-range operands, including those whose most significant bit is set.
- R5: With is_signed = 1, operands are read as two's complement. The quotient is the magnitude quotient, truncated toward zero, and is negated exactly when the two operand sign bits differ.
- R6: With is_signed = 1, a nonzero remainder has the dividend's sign and a magnitude below that of the divisor. For example, -7 / 2 gives quotient -3 and remainder -1.
- R7: A start raised while busy is high is ignored. The running division finishes with its own operands, and no further done pulse follows.
- R8: A zero divisor raises no error. In unsigned mode the quotient is all ones and the remainder equals the dividend. In signed mode the remainder equals the dividend, and the quotient is all ones for a non-negative dividend or 1 for a negative one.
- R9: quotient and remainder change only in the cycle in which done rises, and hold their values at all other times, including during the next division.
- R10: In signed mode, the most negative value divided by -1 gives quotient 0x80000000 and remainder 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, taken only while busy is low |
| is_signed | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | W (32) | Dividend, sampled on the accepting edge |
| divisor | input | W (32) | Divisor, sampled on the accepting edge |
| busy | output | 1 | High from acceptance through the done cycle |
| done | output | 1 | One-cycle pulse when the results are valid |
| quotient | output | W (32) | Quotient of the last completed division |
| remainder | output | W (32) | Remainder of the last completed division |

## Verification
Small unsigned operands check that quotient bits are placed correctly and that the final right shift of the remainder happens. Operands with the top bit set, such as 0xFFFFFFFE / 0xFFFFFFFF and 0x80000000 / 3, separate a correct wide trial subtraction from one that judges the sign by bit 31 alone, and would expose a remainder that lost its top bit. The signed cases -7/2, 7/-2 and -7/-2 each exercise one combination of quotient and remainder negation, while the most negative value divided by -1 and the two zero-divisor cases probe the boundaries of the magnitude conversion. A second start during a running division and a check that results hold during the following operation separate the correct handshake from designs that accept a restart or expose the partial register.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PRE  = 3'd1,
        ST_ITER = 3'd2,
        ST_FIX  = 3'd3,
        ST_DONE = 3'd4
    } div_state_t;

endpackage

// File: rtl/div_magnitude.sv
module div_magnitude #(
    parameter int W = 32
) (
    input  logic [W-1:0] value,
    input  logic         is_signed,
    output logic [W-1:0] mag,
    output logic         neg
);

    always_comb begin
        neg = is_signed & value[W-1];
        mag = neg ? (~value + {{(W-1){1'b0}}, 1'b1}) : value;
    end

endmodule

// File: rtl/div_trial.sv
module div_trial #(
    parameter int W = 32
) (
    input  logic [W:0]   partial,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] diff,
    output logic         fits
);

    logic [W+1:0] wide_diff;
    logic         unused_mid;

    always_comb begin
        wide_diff  = {1'b0, partial} - {2'b00, divisor};
        fits       = ~wide_diff[W+1];
        diff       = wide_diff[W-1:0];
        unused_mid = wide_diff[W];
    end

endmodule

// File: rtl/div_negate.sv
module div_negate #(
    parameter int W = 32
) (
    input  logic [W-1:0] value,
    input  logic         neg,
    output logic [W-1:0] result
);

    always_comb begin
        result = neg ? (~value + {{(W-1){1'b0}}, 1'b1}) : value;
    end

endmodule

// File: rtl/restoring_divider.sv
module restoring_divider
    import div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         is_signed,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);

    localparam int AW = 2 * W + 1;
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    div_state_t state_q, state_d;

    logic [AW-1:0] acc_q;
    logic [W-1:0]  dvr_q;
    logic [CW-1:0] step_q;
    logic          negq_q, negr_q;
    logic [W-1:0]  quo_q, rem_q;

    logic [W-1:0]  mag_a, mag_b;
    logic          neg_a, neg_b;
    logic [W-1:0]  trial_diff;
    logic          trial_fits;
    logic [W-1:0]  rem_corrected;
    logic [W-1:0]  quo_signed, rem_signed;

    div_magnitude #(.W(W)) u_mag_a (
        .value     (dividend),
        .is_signed (is_signed),
        .mag       (mag_a),
        .neg       (neg_a)
    );

    div_magnitude #(.W(W)) u_mag_b (
        .value     (divisor),
        .is_signed (is_signed),
        .mag       (mag_b),
        .neg       (neg_b)
    );

    div_trial #(.W(W)) u_trial (
        .partial (acc_q[AW-1:W]),
        .divisor (dvr_q),
        .diff    (trial_diff),
        .fits    (trial_fits)
    );

    // upper part moved back right by one: drop its lowest bit
    assign rem_corrected = acc_q[AW-1:W+1];

    div_negate #(.W(W)) u_neg_q (
        .value  (acc_q[W-1:0]),
        .neg    (negq_q),
        .result (quo_signed)
    );

    div_negate #(.W(W)) u_neg_r (
        .value  (rem_corrected),
        .neg    (negr_q),
        .result (rem_signed)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_PRE;
            ST_PRE:  state_d = ST_ITER;
            ST_ITER: if (step_q == LAST_STEP) state_d = ST_FIX;
            ST_FIX:  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            dvr_q  <= '0;
            step_q <= '0;
            negq_q <= 1'b0;
            negr_q <= 1'b0;
            quo_q  <= '0;
            rem_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        acc_q  <= {{(W+1){1'b0}}, mag_a};
                        dvr_q  <= mag_b;
                        negq_q <= neg_a ^ neg_b;
                        negr_q <= neg_a;
                    end
                end
                ST_PRE: begin
                    acc_q  <= {acc_q[AW-2:0], 1'b0};
                    step_q <= '0;
                end
                ST_ITER: begin
                    if (trial_fits) acc_q <= {trial_diff, acc_q[W-1:0], 1'b1};
                    else            acc_q <= {acc_q[AW-2:0], 1'b0};
                    step_q <= step_q + 1'b1;
                end
                ST_FIX: begin
                    quo_q <= quo_signed;
                    rem_q <= rem_signed;
                end
                ST_DONE: begin
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
        quotient  = quo_q;
        remainder = rem_q;
    end

endmodule

// File: rtl/div_checker.sv
module div_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         is_signed,
    input logic [W-1:0] dividend,
    input logic [W-1:0] divisor,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder
);

    localparam int LW = $clog2(W + 4) + 1;
    localparam logic [LW-1:0] LAT = LW'(W + 3);

    logic [LW-1:0] lat_q;
    logic [W-1:0]  cap_a, cap_b;
    logic          cap_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
            cap_a <= '0;
            cap_b <= '0;
            cap_s <= 1'b0;
        end else if (start && !busy) begin
            lat_q <= LW'(1);
            cap_a <= dividend;
            cap_b <= divisor;
            cap_s <= is_signed;
        end else if (busy) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_busy_in_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_idle_after_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == LAT));

    p_unsigned_identity_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cap_s && cap_b != '0) |->
        (({{W{1'b0}}, quotient} * {{W{1'b0}}, cap_b} + {{W{1'b0}}, remainder})
            == {{W{1'b0}}, cap_a}) && (remainder < cap_b));

    p_rem_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_s && remainder != '0) |-> (remainder[W-1] == cap_a[W-1]));

    p_hold_results_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> (done || ($stable(quotient) && $stable(remainder))));

endmodule

bind restoring_divider div_checker #(.W(W)) u_div_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .is_signed (is_signed),
    .dividend  (dividend),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder)
);

// File: tb/tb_restoring_divider.sv
module tb_restoring_divider;

    localparam int W = 32;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG = 100000;

    typedef struct {
        logic [W-1:0] q;
        logic [W-1:0] r;
        string        tag;
        int           st;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         is_signed = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done;
    logic [W-1:0] quotient, remainder;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int done_count = 0;
    bit finished = 1'b0;
    logic [W-1:0] last_q = '0;
    logic [W-1:0] last_r = '0;
    exp_t sb[$];

    restoring_divider #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
        .quotient(quotient), .remainder(remainder)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic logic [2*W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                             input logic s);
        logic [W-1:0] ua, ub, uq, ur, q, r;
        ua = (s && a[W-1]) ? -a : a;
        ub = (s && b[W-1]) ? -b : b;
        uq = (ub == '0) ? '1 : ua / ub;
        ur = (ub == '0) ? ua : ua % ub;
        q  = (s && (a[W-1] ^ b[W-1])) ? -uq : uq;
        r  = (s && a[W-1]) ? -ur : ur;
        return {q, r};
    endfunction

    // monitor: pop and compare on every done
    always @(negedge clk) begin
        if (rst_n && done) begin
            done_count++;
            if (sb.size() == 0) begin
                check(1'b0, "R7", "unexpected done", quotient, '0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(quotient == e.q, e.tag, "quotient", quotient, e.q);
                check(remainder == e.r, e.tag, "remainder", remainder, e.r);
                check((cyc - e.st) == W + 2, "R3", "done latency",
                      W'(cyc - e.st), W'(W + 2));
                last_q = e.q;
                last_r = e.r;
            end
        end
    end

    task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                         input string tag);
        exp_t e;
        logic [2*W-1:0] m;
        m = model(a, b, s);
        e.q = m[2*W-1:W];
        e.r = m[W-1:0];
        e.tag = tag;
        @(negedge clk);
        e.st = cyc + 1;
        sb.push_back(e);
        start = 1'b1;
        dividend = a;
        divisor = b;
        is_signed = s;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2", "busy after start", W'(busy), W'(1));
        check(quotient == last_q && remainder == last_r, "R9", "hold during run",
              quotient, last_q);
    endtask

    task automatic finish_op();
        while (!done) @(negedge clk);
        @(negedge clk);
        check(done == 1'b0, "R3", "done one cycle", W'(done), W'(0));
        check(busy == 1'b0, "R2", "busy low after done", W'(busy), W'(1'b0));
    endtask

    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                       input string tag);
        issue(a, b, s, tag);
        finish_op();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] lcg;
        int dc;
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0, "R1", "handshake in reset", W'({busy, done}), '0);
        check(quotient == '0 && remainder == '0, "R1", "results in reset", quotient, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && quotient == '0 && remainder == '0, "R1", "after reset",
              remainder, '0);

        // unsigned (R4)
        run(32'd7, 32'd2, 1'b0, "R4");
        run(32'd100, 32'd7, 1'b0, "R4");
        run(32'd5, 32'd9, 1'b0, "R4");
        run(32'd0, 32'd5, 1'b0, "R4");
        run(32'hFFFF_FFFF, 32'd1, 1'b0, "R4");
        run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R4");
        run(32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0, "R4");
        run(32'h8000_0000, 32'd3, 1'b0, "R4");
        run(32'hDEAD_BEEF, 32'h8000_0001, 1'b0, "R4");

        // signed (R5, R6, R10)
        run(-32'sd7, 32'sd2, 1'b1, "R6");
        run(32'sd7, -32'sd2, 1'b1, "R5");
        run(-32'sd7, -32'sd2, 1'b1, "R6");
        run(-32'sd100, 32'sd7, 1'b1, "R5");
        run(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, "R5");
        run(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R10");

        // divide by zero (R8)
        run(32'd12345, 32'd0, 1'b0, "R8");
        run(32'hFFFF_FFFF, 32'd0, 1'b1, "R8");
        run(32'd5, 32'd0, 1'b1, "R8");

        // pseudo-random mix
        lcg = 32'h1234_5678;
        for (int i = 0; i < 24; i++) begin
            logic [W-1:0] a, b;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            a = lcg;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            b = (i % 3 == 0) ? (lcg >> (i % 29)) : lcg;
            run(a, b, i[0], i[0] ? "R5" : "R4");
        end

        // start while busy (R7)
        dc = done_count;
        issue(32'd1000, 32'd3, 1'b0, "R7");
        repeat (5) @(negedge clk);
        start = 1'b1;
        dividend = 32'd77;
        divisor = 32'd5;
        @(negedge clk);
        start = 1'b0;
        finish_op();
        repeat (W + 8) @(negedge clk);
        check(done_count == dc + 1, "R7", "single done", W'(done_count - dc), W'(1));

        // results held while idle (R9)
        check(quotient == 32'd333 && remainder == 32'd1, "R9", "hold while idle",
              quotient, 32'd333);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule